// File: doc/BRIEF.md
# Conversion Sequencer with Settling Timer

This block paces conversions for the back end of a delta-sigma converter that has two filter paths. A path-select bit, a mode bit and a 3-bit rate code choose the conversion settings. A single-cycle START strobe captures those settings and begins a conversion. The block then counts the number of sample-clock periods that the captured settings need to settle. When the count runs out, it emits a one-clock data-ready pulse together with a valid flag, and the next conversion begins on its own.

Two cases stop the free-running sequence. In the first, a setting changes while a conversion is running. The running conversion still finishes and pulses, but its result is flagged invalid. The sequencer then parks and waits for a new START. In the second, a START arrives during a conversion. That conversion is abandoned without a pulse and counting restarts from zero under the settings present at the new START.

The controller has three states. ST_IDLE waits for START and is entered after reset or after a tainted conversion. ST_RUN counts a clean conversion. ST_TAINT finishes a conversion whose settings were disturbed. The transitions are:
- T_START: any state goes to ST_RUN on START.
- T_RELOAD: ST_RUN returns to ST_RUN on a clean completion.
- T_DISTURB: ST_RUN goes to ST_TAINT on a setting change.
- T_PARK: ST_RUN on a completion that coincides with a change, or ST_TAINT on any completion, goes to ST_IDLE.

Top module: `conv_seq_ctrl`

## Requirements
- R1: After reset, busy_o, drdy_o, valid_o and rate_err_o are 0, and no drdy_o pulse appears until START is asserted.
- R2: A START sampled at clock edge E sets busy_o from the cycle after E. The first drdy_o of the new conversion appears exactly L cycles after E, where L is the settling length of the settings captured at E.
- R3: With path_sel_i=1 and fast_mode_i=0, the rate codes 0, 1, 2 and 3 give L = 556, 300, 172 and 116 clock periods.
- R4: With path_sel_i=0, or with fast_mode_i=1, L equals the parameter ALT_LEN, whatever the rate code.
- R5: After a clean completion, the next conversion follows without START. drdy_o then repeats every L cycles with valid_o=1.
- R6: drdy_o is high for exactly one clock per completion.
- R7: If any setting differs from the captured value at a clock edge during a conversion, that conversion still completes on time. Its pulse carries valid_o=0, busy_o is 0 from the pulse cycle onward, and no drdy_o appears until the next START.
- R8: A START during a conversion abandons it. No pulse is produced for the abandoned conversion, and the next pulse comes L cycles after the new START edge.
- R9: A START sampled at the same edge that would complete a conversion suppresses that pulse and begins a new conversion.
- R10: Rate codes 4 to 7 (bit 2 set) in low-latency single-cycle mode settle with the code-0 length. A START that captures such a code sets rate_err_o, which holds until the next START re-evaluates it.
- R11: Setting changes while the sequencer is idle have no effect: busy_o and drdy_o stay 0.
- R12: A setting change seen at the completing edge itself marks that pulse invalid and parks the sequencer, as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| path_sel_i | input | 1 | 1 selects the low-latency path, 0 selects the wide-bandwidth path |
| fast_mode_i | input | 1 | 0 selects single-cycle settling, 1 selects fast response |
| rate_code_i | input | 3 | Data-rate code |
| start_i | input | 1 | Single-cycle START strobe |
| busy_o | output | 1 | High while a conversion is counting |
| drdy_o | output | 1 | One-cycle data-ready pulse |
| valid_o | output | 1 | Validity of the most recent result, meaningful with drdy_o |
| rate_err_o | output | 1 | Sticky flag for a reserved rate code captured at START |

## Verification
Two events can land on the completing edge of a conversion: a START strobe and a change to a setting. The bench counts edges from a known pulse and aims a START at exactly the completing edge, then judges that no pulse appears and that a new full-length conversion follows. In a separate run it aims a rate-code change at that edge and expects a pulse with valid_o low and busy_o already low. A behavioural model built on integers predicts every output on every cycle alongside these targeted checks.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_TAINT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic       path_ll;
        logic       fast_mode;
        logic [2:0] rate;
    } seq_cfg_t;

    // Codes with the top bit set are reserved
    function automatic logic rate_reserved(input logic [2:0] code);
        return code[2];
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/conv_settle_lut.sv
module conv_settle_lut
    import conv_seq_pkg::*;
#(
    parameter int unsigned LEN0    = 556,
    parameter int unsigned LEN1    = 300,
    parameter int unsigned LEN2    = 172,
    parameter int unsigned LEN3    = 116,
    parameter int unsigned ALT_LEN = 64,
    parameter int unsigned CNT_W   = 10
) (
    input  seq_cfg_t           cfg_i,
    output logic [CNT_W-1:0]   len_o
);
    localparam int unsigned NUM_CODES = 4;
    localparam int unsigned LL_TAB [NUM_CODES] = '{LEN0, LEN1, LEN2, LEN3};

    logic [CNT_W-1:0] tab_len [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_tab
        assign tab_len[g] = CNT_W'(LL_TAB[g]);
    end

    always_comb begin
        if (!cfg_i.path_ll || cfg_i.fast_mode) begin
            len_o = CNT_W'(ALT_LEN);
        end else if (rate_reserved(cfg_i.rate)) begin
            len_o = tab_len[0];
        end else begin
            len_o = tab_len[cfg_i.rate[1:0]];
        end
    end

endmodule

// File: rtl/conv_settle_timer.sv
module conv_settle_timer #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    assign last_o = (cnt_q == (len_i - CNT_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (adv_i) begin
            cnt_q <= last_o ? '0 : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/conv_cfg_watch.sv
module conv_cfg_watch
    import conv_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     capture_i,
    input  seq_cfg_t cfg_i,
    output seq_cfg_t snap_o,
    output logic     changed_o
);
    seq_cfg_t snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (capture_i) begin
            snap_q <= cfg_i;
        end
    end

    assign snap_o    = snap_q;
    assign changed_o = (cfg_i != snap_q);

endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int unsigned LL_LEN0 = 556,
    parameter int unsigned LL_LEN1 = 300,
    parameter int unsigned LL_LEN2 = 172,
    parameter int unsigned LL_LEN3 = 116,
    parameter int unsigned ALT_LEN = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       path_sel_i,
    input  logic       fast_mode_i,
    input  logic [2:0] rate_code_i,
    input  logic       start_i,
    output logic       busy_o,
    output logic       drdy_o,
    output logic       valid_o,
    output logic       rate_err_o
);
    localparam int unsigned MAX_LEN = max2(max2(max2(LL_LEN0, LL_LEN1),
                                                max2(LL_LEN2, LL_LEN3)), ALT_LEN);
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

    seq_state_e       state_q, state_d;
    seq_cfg_t         cfg_live, cfg_snap;
    logic             cfg_changed;
    logic [CNT_W-1:0] settle_len;
    logic             cnt_last, counting, conv_done;
    logic             drdy_q, valid_q, err_q;

    assign cfg_live.path_ll   = path_sel_i;
    assign cfg_live.fast_mode = fast_mode_i;
    assign cfg_live.rate      = rate_code_i;

    assign counting  = (state_q != ST_IDLE) && !start_i;
    assign conv_done = counting && cnt_last;

    conv_cfg_watch u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (start_i),
        .cfg_i     (cfg_live),
        .snap_o    (cfg_snap),
        .changed_o (cfg_changed)
    );

    conv_settle_lut #(
        .LEN0    (LL_LEN0),
        .LEN1    (LL_LEN1),
        .LEN2    (LL_LEN2),
        .LEN3    (LL_LEN3),
        .ALT_LEN (ALT_LEN),
        .CNT_W   (CNT_W)
    ) u_lut (
        .cfg_i (cfg_snap),
        .len_o (settle_len)
    );

    conv_settle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i),
        .adv_i   (counting),
        .len_i   (settle_len),
        .last_o  (cnt_last)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) state_d = ST_RUN;                 // T_START
            end
            ST_RUN: begin
                if (start_i)                      state_d = ST_RUN;   // T_START
                else if (cnt_last && cfg_changed) state_d = ST_IDLE;  // T_PARK
                else if (cnt_last)                state_d = ST_RUN;   // T_RELOAD
                else if (cfg_changed)             state_d = ST_TAINT; // T_DISTURB
            end
            ST_TAINT: begin
                if (start_i)       state_d = ST_RUN;           // T_START
                else if (cnt_last) state_d = ST_IDLE;          // T_PARK
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drdy_q  <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            drdy_q <= conv_done;
            if (conv_done) begin
                valid_q <= (state_q == ST_RUN) && !cfg_changed;
            end
            if (start_i) begin
                err_q <= path_sel_i && !fast_mode_i && rate_reserved(rate_code_i);
            end
        end
    end

    assign busy_o     = (state_q != ST_IDLE);
    assign drdy_o     = drdy_q;
    assign valid_o    = valid_q;
    assign rate_err_o = err_q;

endmodule

// File: rtl/conv_seq_ctrl_chk.sv
module conv_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic busy_o,
    input logic drdy_o,
    input logic valid_o,
    input logic rate_err_o
);
    // R6
    drdy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_o |=> !drdy_o);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (busy_o && !drdy_o));

    // R7
    invalid_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_o && !valid_o) |-> !busy_o);

    // R5
    valid_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drdy_o && valid_o) |-> busy_o);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!busy_o && !drdy_o));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_err_o && !start_i) |=> rate_err_o);

endmodule

bind conv_seq_ctrl conv_seq_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .drdy_o     (drdy_o),
    .valid_o    (valid_o),
    .rate_err_o (rate_err_o)
);

// File: tb/tb_conv_seq_ctrl.sv
module tb_conv_seq_ctrl;
    localparam int ALT = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       path = 1'b1;
    logic       mode = 1'b0;
    logic [2:0] code = 3'd0;
    logic       start = 1'b0;
    logic       busy, drdy, valid, err;

    int  checks = 0;
    int  fails  = 0;
    bit  ended  = 0;

    always #10 clk = ~clk;

    conv_seq_ctrl #(.ALT_LEN(ALT)) dut (
        .clk(clk), .rst_n(rst_n), .path_sel_i(path), .fast_mode_i(mode),
        .rate_code_i(code), .start_i(start), .busy_o(busy), .drdy_o(drdy),
        .valid_o(valid), .rate_err_o(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_len(input int p, input int m, input int c);
        if (p == 0 || m == 1) return ALT;
        case (c)
            1: return 300;
            2: return 172;
            3: return 116;
            default: return 556;
        endcase
    endfunction

    // Behavioural reference model
    bit m_act, m_taint, m_drdy, m_valid, m_err;
    int m_cnt, m_len, s_p, s_m, s_c;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_taint = 0; m_drdy = 0; m_valid = 0; m_err = 0;
            m_cnt = 0; m_len = 0; s_p = 0; s_m = 0; s_c = 0;
        end else if (start) begin
            m_act = 1; m_taint = 0; m_drdy = 0; m_cnt = 0;
            s_p = int'(path); s_m = int'(mode); s_c = int'(code);
            m_len = exp_len(s_p, s_m, s_c);
            m_err = (s_p == 1 && s_m == 0 && s_c >= 4);
        end else if (m_act) begin
            if (int'(path) != s_p || int'(mode) != s_m || int'(code) != s_c) m_taint = 1;
            if (m_cnt == m_len - 1) begin
                m_drdy = 1; m_valid = !m_taint; m_cnt = 0;
                if (m_taint) m_act = 0;
            end else begin
                m_drdy = 0; m_cnt++;
            end
        end else begin
            m_drdy = 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !ended) begin
            chk(busy == m_act, "R2", "model busy", busy, m_act);
            chk(drdy == m_drdy, "R6", "model drdy", drdy, m_drdy);
            if (m_drdy) chk(valid == m_valid, "R7", "model valid", valid, m_valid);
            chk(err == m_err, "R10", "model rate_err", err, m_err);
        end
    end

    task automatic finish_run();
        ended = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic next_pulse(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!drdy && gap < 2000);
    endtask

    task automatic run_len(input int p, input int m, input int c, input string req);
        int g;
        int l;
        l = exp_len(p, m, c);
        path = p[0]; mode = m[0]; code = c[2:0];
        pulse_start();
        next_pulse(g);
        chk(g == l, req, "first settle gap", g, l);
        chk(valid == 1'b1, req, "first result valid", valid, 1);
        @(negedge clk);
        chk(drdy == 1'b0, "R6", "pulse width", drdy, 0);
        next_pulse(g);
        chk(g == l - 1, "R5", "free-run gap", g + 1, l);
        chk(valid == 1'b1 && busy == 1'b1, "R5", "free-run valid", valid, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        int g;
        repeat (3) @(negedge clk);
        chk(busy == 0 && drdy == 0 && valid == 0 && err == 0, "R1", "reset outputs",
            {busy, drdy, valid, err}, 0);
        rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(busy == 0 && drdy == 0, "R1", "no activity before START", {busy, drdy}, 0);

        // R3 / R5 / R6: low-latency single-cycle lengths
        run_len(1, 0, 0, "R3");
        run_len(1, 0, 1, "R3");
        run_len(1, 0, 2, "R3");
        run_len(1, 0, 3, "R3");
        // R4: alternative length
        run_len(0, 0, 2, "R4");
        run_len(1, 1, 0, "R4");

        // R7: change mid-conversion
        path = 1; mode = 0; code = 3;
        pulse_start();
        repeat (50) @(negedge clk);
        code = 3'd2;
        next_pulse(g);
        chk(g == 116 - 50, "R7", "tainted completes on time", g + 50, 116);
        chk(valid == 1'b0, "R7", "tainted result invalid", valid, 0);
        chk(busy == 1'b0, "R7", "parked after taint", busy, 0);
        next_pulse(g);
        chk(g >= 2000, "R7", "no pulse without START", g, 2000);

        // R11: changes while idle
        path = 0; repeat (20) @(negedge clk);
        mode = 1; code = 3'd1; repeat (20) @(negedge clk);
        chk(busy == 0 && drdy == 0, "R11", "idle ignores changes", {busy, drdy}, 0);

        // R8: abort by START
        path = 1; mode = 0; code = 3;
        pulse_start();
        repeat (60) @(negedge clk);
        pulse_start();
        next_pulse(g);
        chk(g == 116, "R8", "restart gap", g + 61, 116 + 61);

        // R9: START at the completing edge
        next_pulse(g);
        repeat (115) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(drdy == 1'b0, "R9", "pulse suppressed", drdy, 0);
        next_pulse(g);
        chk(g == 116, "R9", "new conversion length", g, 116);

        // R12: change at the completing edge
        repeat (115) @(negedge clk);
        code = 3'd0;
        @(negedge clk);
        chk(drdy == 1'b1, "R12", "pulse still produced", drdy, 1);
        chk(valid == 1'b0, "R12", "pulse invalid", valid, 0);
        chk(busy == 1'b0, "R12", "parked", busy, 0);

        // R10: reserved rate code
        code = 3'd5;
        pulse_start();
        chk(err == 1'b1, "R10", "reserved flag set", err, 1);
        next_pulse(g);
        chk(g == 556, "R10", "reserved uses code-0 length", g, 556);
        repeat (10) @(negedge clk);
        chk(err == 1'b1, "R10", "flag sticky", err, 1);
        code = 3'd1;
        pulse_start();
        chk(err == 1'b0, "R10", "flag cleared by START", err, 0);
        repeat (20) @(negedge clk);

        finish_run();
    end

endmodule